// File: doc/BRIEF.md
# Timer Compare Unit with Forced Strobes

The block is a 16-bit up-counter with three output compare channels. The counter advances on cycles where a timer-clock enable is high. It runs either as a free-running counter or in clear-on-compare mode, where compare register A sets the top value. Each channel compares the counter with its own 16-bit compare register. On a match, the channel sets a sticky match flag and updates its waveform output according to a 2-bit action field.

A processor reaches the block over an 8-bit register bus. The counter and the three compare registers are each split into a low and a high byte. One shared temporary byte makes every 16-bit read and write atomic. A strobe register lets software force a compare event on any channel. The forced event changes the waveform output only: it sets no flag and never clears the counter. Any write to the counter suppresses compare matches for the next timer tick.

The waveform-mode field has two codes that select non-PWM operation, normal and clear-on-compare. The other two codes are treated as PWM selections. In those codes the counter keeps counting as in normal mode, real matches still act, and the force strobes are ignored.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After the active-low asynchronous reset, every readable address reads 0x00 and all three waveform outputs are 0.
- R2: The counter increases by one on each cycle with `tick_i` high. It holds its value on cycles with `tick_i` low, and it wraps from 0xFFFF to 0x0000 in normal mode (mode field at address 1 equal to 0).
- R3: In clear-on-compare mode (mode field 1), a tick taken while the counter equals compare register A loads 0x0000 instead of incrementing.
- R4: A match is a tick taken while the counter equals a channel's compare register. The action field at address 0 sets what the waveform output does on a match or a forced event: bits 1:0 for A, 3:2 for B, 5:4 for C. The codes are 00 hold, 01 toggle, 10 drive 0 and 11 drive 1.
- R5: A match sets the channel's flag in the flag register at address 3 (bit 0 A, bit 1 B, bit 2 C). Writing a one to a flag bit clears it.
- R6: Writing a one to bit 7, bit 6 or bit 5 of the strobe register at address 2 forces an event on channel A, B or C. The event applies the channel's current action on the next cycle. It sets no flag and does not change the counter, even on channel A in clear-on-compare mode.
- R7: When the mode field is 2 or 3, writes to the strobe register leave the waveform outputs unchanged.
- R8: The strobe register at address 2 always reads 0x00.
- R9: A write to the counter's low byte suppresses matches on every channel for the next tick only. The tick after that compares normally.
- R10: The 16-bit registers sit at address pairs: counter 4/5, compare A 6/7, compare B 8/9, compare C 10/11, with the low byte at the even address. Writing the high address loads only the temporary byte, and writing the low address commits {temporary, data} in one cycle. Reading the low address copies the register's current high byte into the temporary byte, and reading the high address returns the temporary byte.
- R11: A single temporary byte serves all four 16-bit registers, so a high-byte write to one register followed by a low-byte write to another commits that high byte to the second register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer-clock enable; counter advances when high |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (drives temporary-byte latching) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| oc_o | output | 3 | Waveform outputs, bit 0 A, bit 1 B, bit 2 C |

## Verification
The waveform outputs and flags record history, so an event that is wrongly taken, missed or doubled stays visible at the ports until software overwrites it. Such an error shows on `oc_o` or at address 3 one cycle after the tick or strobe that caused it. A wrong counter value, such as a missing wrap, a wrong clear, or a suppression window held for too many or too few ticks, appears in the counter readback straight away. It also shifts the flag pattern seen after the next ticks. A fault in the temporary byte only appears when bytes are combined, so the bench reads and writes bytes across register boundaries and ticks between a low-byte read and the matching high-byte read.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int NCH = 3;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_TGL  = 2'd1,
    ACT_LOW  = 2'd2,
    ACT_HIGH = 2'd3
  } act_e;

  localparam logic [1:0] WM_NORMAL = 2'd0;
  localparam logic [1:0] WM_CTC    = 2'd1;

  localparam logic [3:0] ADR_ACT   = 4'd0;
  localparam logic [3:0] ADR_MODE  = 4'd1;
  localparam logic [3:0] ADR_STRB  = 4'd2;
  localparam logic [3:0] ADR_FLAG  = 4'd3;
  localparam logic [3:0] ADR_W16_LO = 4'd4;
  localparam logic [3:0] ADR_W16_HI = 4'd11;
endpackage

// File: rtl/tcu_counter.sv
module tcu_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic          ctc_i,
  input  logic          top_hit_i,
  output logic [CW-1:0] cnt_o,
  output logic          cmp_en_o
);
  logic blk_q;

  // compares are live on a tick that is neither a load nor the tick after one
  assign cmp_en_o = tick_i & ~ld_i & ~blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      blk_q <= 1'b0;
    end else begin
      if (ld_i)
        cnt_o <= ld_val_i;
      else if (tick_i)
        cnt_o <= (ctc_i && top_hit_i) ? '0 : cnt_o + 1'b1;

      if (ld_i)
        blk_q <= 1'b1;
      else if (tick_i)
        blk_q <= 1'b0;
    end
  end

  assert_load_commit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_o == $past(ld_val_i));

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i && !(ctc_i && top_hit_i)) |=> cnt_o == CW'($past(cnt_o) + 1'b1));

  assert_ctc_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i && ctc_i && top_hit_i) |=> cnt_o == '0);

  assert_load_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> !cmp_en_o);
endmodule

// File: rtl/tcu_channel.sv
module tcu_channel
  import tcu_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  input  logic [1:0]    act_i,
  input  logic          cmp_en_i,
  input  logic          force_i,
  input  logic          flag_clr_i,
  output logic          hit_o,
  output logic          oc_o,
  output logic          flag_o
);
  logic evt;

  assign hit_o = cmp_en_i & (cnt_i == cmp_i);
  assign evt   = hit_o | force_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_o   <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (evt) begin
        unique case (act_e'(act_i))
          ACT_HOLD: oc_o <= oc_o;
          ACT_TGL:  oc_o <= ~oc_o;
          ACT_LOW:  oc_o <= 1'b0;
          ACT_HIGH: oc_o <= 1'b1;
        endcase
      end
      if (hit_o)
        flag_o <= 1'b1;
      else if (flag_clr_i)
        flag_o <= 1'b0;
    end
  end

  assert_force_no_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !hit_o && !flag_clr_i) |=> flag_o == $past(flag_o));

  assert_hit_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> flag_o);

  assert_act_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && act_i == 2'd3) |=> oc_o);

  assert_act_tgl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && act_i == 2'd1) |=> oc_o != $past(oc_o));

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt |=> $stable(oc_o));
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
  import tcu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [NCH-1:0] oc_o
);
  localparam int CW  = 2 * DW;
  localparam int NW  = NCH + 1;   // counter plus compare registers
  localparam int IW  = $clog2(NW);

  logic [2*NCH-1:0] act_q;
  logic [1:0]       wm_q;
  logic [DW-1:0]    tmp_q;
  logic [CW-1:0]    cmp_q [NCH];
  logic [CW-1:0]    w16   [NW];
  logic [CW-1:0]    cnt;
  logic             cmp_en;
  logic [NCH-1:0]   hit, flag, force_v, flag_clr;

  // 16-bit window decode
  logic          in_w16, lo_sel;
  logic [AW-1:0] w_off;
  logic [IW-1:0] w_idx;

  assign in_w16 = (addr_i >= AW'(ADR_W16_LO)) && (addr_i <= AW'(ADR_W16_HI));
  assign w_off  = addr_i - AW'(ADR_W16_LO);
  assign w_idx  = w_off[IW:1];
  assign lo_sel = ~w_off[0];

  assign w16[0] = cnt;
  for (genvar i = 0; i < NCH; i++) begin : g_w16
    assign w16[i+1] = cmp_q[i];
  end

  logic ld_cnt;
  assign ld_cnt = wr_i & in_w16 & lo_sel & (w_idx == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      wm_q  <= '0;
      tmp_q <= '0;
    end else begin
      if (wr_i && addr_i == AW'(ADR_ACT))  act_q <= wdata_i[2*NCH-1:0];
      if (wr_i && addr_i == AW'(ADR_MODE)) wm_q  <= wdata_i[1:0];
      if (wr_i && in_w16 && !lo_sel)
        tmp_q <= wdata_i;
      else if (rd_i && in_w16 && lo_sel)
        tmp_q <= w16[w_idx][CW-1:DW];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cmp_q[i] <= '0;
      else if (wr_i && in_w16 && lo_sel && w_idx == IW'(i + 1))
        cmp_q[i] <= {tmp_q, wdata_i};
    end

    // strobe bits run downward from the MSB: A at DW-1
    assign force_v[i]  = wr_i & (addr_i == AW'(ADR_STRB)) & wdata_i[DW-1-i] & ~wm_q[1];
    assign flag_clr[i] = wr_i & (addr_i == AW'(ADR_FLAG)) & wdata_i[i];

    tcu_channel #(.CW(CW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt),
      .cmp_i      (cmp_q[i]),
      .act_i      (act_q[2*i +: 2]),
      .cmp_en_i   (cmp_en),
      .force_i    (force_v[i]),
      .flag_clr_i (flag_clr[i]),
      .hit_o      (hit[i]),
      .oc_o       (oc_o[i]),
      .flag_o     (flag[i])
    );
  end

  tcu_counter #(.CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .ld_i      (ld_cnt),
    .ld_val_i  ({tmp_q, wdata_i}),
    .ctc_i     (wm_q == WM_CTC),
    .top_hit_i (hit[0]),
    .cnt_o     (cnt),
    .cmp_en_o  (cmp_en)
  );

  always_comb begin
    rdata_o = '0;
    if (in_w16)
      rdata_o = lo_sel ? w16[w_idx][DW-1:0] : tmp_q;
    else if (addr_i == AW'(ADR_ACT))
      rdata_o = DW'(act_q);
    else if (addr_i == AW'(ADR_MODE))
      rdata_o = DW'(wm_q);
    else if (addr_i == AW'(ADR_FLAG))
      rdata_o = DW'(flag);
  end

  assert_pwm_no_force_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wm_q[1] |-> force_v == '0);

  assert_tmp_hi_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_w16 && !lo_sel) |=> tmp_q == $past(wdata_i));
endmodule

// File: tb/tb_tmr_cmp_unit.sv
module tb_tmr_cmp_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [2:0] oc_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  tmr_cmp_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .oc_o(oc_o)
  );

  // op: 0 write, 1 read-compare, 2 ticks (count in data), 3 compare oc_o
  localparam int NV = 31;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 4'd0,  8'h39, 8'h00, 4'd4},   // R4 actions: A tgl, B low, C high
    {2'd1, 4'd0,  8'h00, 8'h39, 4'd4},
    {2'd0, 4'd7,  8'h00, 8'h00, 4'd10},
    {2'd0, 4'd6,  8'h05, 8'h00, 4'd10},
    {2'd0, 4'd9,  8'h00, 8'h00, 4'd10},
    {2'd0, 4'd8,  8'h03, 8'h00, 4'd10},
    {2'd0, 4'd11, 8'h00, 8'h00, 4'd10},
    {2'd0, 4'd10, 8'h04, 8'h00, 4'd10},
    {2'd1, 4'd6,  8'h00, 8'h05, 4'd10},
    {2'd1, 4'd7,  8'h00, 8'h00, 4'd10},
    {2'd0, 4'd9,  8'h12, 8'h00, 4'd11},  // R11 high byte staged via B
    {2'd0, 4'd6,  8'h34, 8'h00, 4'd11},  // committed into A
    {2'd1, 4'd6,  8'h00, 8'h34, 4'd11},
    {2'd1, 4'd7,  8'h00, 8'h12, 4'd11},
    {2'd1, 4'd8,  8'h00, 8'h03, 4'd11},
    {2'd1, 4'd9,  8'h00, 8'h00, 4'd11},
    {2'd0, 4'd7,  8'h00, 8'h00, 4'd10},
    {2'd0, 4'd6,  8'h05, 8'h00, 4'd10},
    {2'd2, 4'd0,  8'd3,  8'h00, 4'd2},
    {2'd1, 4'd4,  8'h00, 8'h03, 4'd2},
    {2'd1, 4'd3,  8'h00, 8'h00, 4'd5},
    {2'd2, 4'd0,  8'd1,  8'h00, 4'd5},
    {2'd1, 4'd3,  8'h00, 8'h02, 4'd5},   // R5 B matched at 3
    {2'd2, 4'd0,  8'd1,  8'h00, 4'd5},
    {2'd1, 4'd3,  8'h00, 8'h06, 4'd5},
    {2'd2, 4'd0,  8'd1,  8'h00, 4'd5},
    {2'd1, 4'd3,  8'h00, 8'h07, 4'd5},
    {2'd1, 4'd4,  8'h00, 8'h06, 4'd2},
    {2'd3, 4'd0,  8'h00, 8'h05, 4'd4},   // R4 A toggled, B low, C high
    {2'd0, 4'd3,  8'h07, 8'h00, 4'd5},
    {2'd1, 4'd3,  8'h00, 8'h00, 4'd5}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input int req);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    #1 check(rdata_o, exp, req, $sformatf("read addr %0d", a));
    @(posedge clk_i);
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i); tick_i = 1'b1;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic oc_chk(input logic [2:0] exp, input int req);
    @(negedge clk_i);
    check({5'd0, oc_o}, {5'd0, exp}, req, "oc_o");
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int a = 0; a < 12; a++) rd(4'(a), 8'h00, 1);
    oc_chk(3'b000, 1);

    for (int k = 0; k < NV; k++) begin
      logic [25:0] v;
      v = VEC[k];
      case (v[25:24])
        2'd0: wr(v[23:20], v[19:12]);
        2'd1: rd(v[23:20], v[11:4], int'(v[3:0]));
        2'd2: ticks(int'(v[19:12]));
        default: oc_chk(v[6:4], int'(v[3:0]));
      endcase
    end
    rd(4'd2, 8'h00, 8);  // R8 strobe register reads zero

    // R10 low read latches high byte; later high read returns latched copy
    wr(4'd5, 8'h12); wr(4'd4, 8'hFF);
    rd(4'd4, 8'hFF, 10);
    ticks(1);
    rd(4'd5, 8'h12, 10);
    rd(4'd4, 8'h00, 2);
    rd(4'd5, 8'h13, 10);

    // R2 wrap and hold
    wr(4'd5, 8'hFF); wr(4'd4, 8'hFE);
    ticks(2);
    rd(4'd4, 8'h00, 2); rd(4'd5, 8'h00, 2);
    repeat (3) @(negedge clk_i);
    rd(4'd4, 8'h00, 2);
    wr(4'd3, 8'h07);

    // R3 clear-on-compare with A = 5
    wr(4'd1, 8'h01);
    wr(4'd5, 8'h00); wr(4'd4, 8'h00);
    ticks(5);
    rd(4'd4, 8'h05, 3);
    ticks(1);
    rd(4'd4, 8'h00, 3);
    rd(4'd3, 8'h07, 5);
    oc_chk(3'b100, 4);
    wr(4'd3, 8'h07);

    // R6 forced events
    ticks(2);
    wr(4'd2, 8'h80);
    oc_chk(3'b101, 6);
    rd(4'd3, 8'h00, 6);
    rd(4'd4, 8'h02, 6);
    wr(4'd0, 8'h2D);     // A tgl, B high, C low
    wr(4'd2, 8'h40);
    wr(4'd2, 8'h20);
    oc_chk(3'b011, 6);
    rd(4'd3, 8'h00, 6);
    rd(4'd2, 8'h00, 8);

    // R7 strobes ignored in PWM codes
    wr(4'd1, 8'h02);
    wr(4'd2, 8'hE0);
    oc_chk(3'b011, 7);
    wr(4'd1, 8'h03);
    wr(4'd2, 8'hE0);
    oc_chk(3'b011, 7);

    // R4 hold code ignores forced event
    wr(4'd1, 8'h00);
    wr(4'd0, 8'h00);
    wr(4'd2, 8'hE0);
    oc_chk(3'b011, 4);

    // R9 counter write blocks exactly one tick
    wr(4'd3, 8'h07);
    wr(4'd5, 8'h00); wr(4'd4, 8'h03);
    ticks(1);
    rd(4'd3, 8'h00, 9);
    ticks(1);
    rd(4'd3, 8'h04, 9);
    rd(4'd4, 8'h05, 9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule